// File: doc/BRIEF.md
# Card Clock Divider Generator

This block derives a memory-card bus clock from its own input clock, which stands for the fast source oscillator. Two 32-bit configuration registers sit behind a small write/read register bus. One holds a 4-bit source-select code and the other holds a 3-bit ratio code plus a mode flag. The ratio code picks one of eight power-of-two division ratios. The set is sparse: 1, 2, 4, 8, 16, 32, 128 and 512. The output clock runs only for source codes 1 to 7. For every other code it is held low.

A new ratio or a new gating decision is never applied mid-period. It is taken over only where the divided clock would next rise, so the card never sees a shortened high or low phase. A registered enable strobe marks the first source cycle of every divided period for logic that runs on the source clock. At ratio 1 the card clock is the source clock passed through a clock-gate enable and not a toggling register.

Top module: `card_clkgen`

## Requirements
- R1: While reset is asserted and afterwards until a register write, both registers read zero, `card_clk` stays low and `card_ce` stays low.
- R2: The ratio code sits in bits 30:28 of the divider register. Codes 0 to 7 give a card clock period of 1, 2, 4, 8, 16, 32, 128 and 512 source cycles.
- R3: For a ratio N of 2 or more, `card_clk` is high for the first N/2 source cycles of each period and low for the remaining N/2.
- R4: A change of ratio code or source code takes effect only at the end of the current divided period, at the next rising edge of `card_clk`. The divider state is never changed in the middle of a period.
- R5: `card_ce` is high for exactly the first source cycle of each divided period and is low otherwise.
- R6: At ratio 1, `card_clk` equals the source clock (high in its high phase, low in its low phase) and `card_ce` is high on every cycle.
- R7: The source code sits in bits 19:16 of the source register. Codes 1 to 7 enable the output. Codes 0 and 8 to 15 hold `card_clk` and `card_ce` low.
- R8: A write to address 2 changes only bits 31:28 of the divider register, taken from `wr_data[31:28]`. Bits 27:0 keep their value.
- R9: Bit 31 of the divider register reads as 1 whenever the source code is nonzero. Otherwise it reads as the stored bit.
- R10: A write to address 0 loads the whole divider register, and a write to address 1 loads the whole source register. Reads at addresses 0 and 2 return the divider register, address 1 returns the source register and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 divider full, 1 source, 2 divider field |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| card_clk | output | 1 | Gated, divided card clock |
| card_ce | output | 1 | One-cycle enable at each divided rising edge |

## Verification
The hard coincidence is a register write that lands in the same source cycle as the end of a divided period. At that edge the divider reloads from the old settings, and the new settings wait a whole period. The bench provokes this by writing ratio and source codes at arbitrary phases, including back-to-back with period boundaries. Its behavioural model applies each write only after that edge's reload decision. `card_clk` and `card_ce` are compared against the model twice per source cycle, once in the high phase and once in the low phase, so a runt or early switch shows as a mismatch.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 2;
  localparam int MAX_SHIFT = 9;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int CODE_W    = 3;
  localparam int SRC_W     = 4;
  localparam int DIV_LSB   = 28;
  localparam int SRC_LSB   = 16;

  localparam logic [ADDR_W-1:0] A_DIV_FULL = 2'd0;
  localparam logic [ADDR_W-1:0] A_SRC      = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV_FLD  = 2'd2;

  // sparse ratio map: shifts 0..5 then 7 and 9
  function automatic logic [SH_W-1:0] ratio_shift(input logic [CODE_W-1:0] code);
    logic [SH_W-1:0] s;
    case (code)
      3'd6:    s = SH_W'(7);
      3'd7:    s = SH_W'(9);
      default: s = SH_W'(code);
    endcase
    return s;
  endfunction

  function automatic logic src_runs(input logic [SRC_W-1:0] code);
    return (code != '0) && (code[SRC_W-1] == 1'b0);
  endfunction
endpackage

// File: rtl/ckg_regs.sv
module ckg_regs
  import card_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [CODE_W-1:0] ratio_code,
  output logic [SRC_W-1:0]  src_code,
  output logic [DIV_LSB-1:0] div_low
);
  logic [REG_W-1:0] div_q, div_d;
  logic [REG_W-1:0] src_q, src_d;
  logic             src_nz;
  logic [REG_W-1:0] div_view;

  always_comb begin
    div_d = div_q;
    src_d = src_q;
    if (wr_en) begin
      case (wr_addr)
        A_DIV_FULL: div_d = wr_data;
        A_SRC:      src_d = wr_data;
        A_DIV_FLD:  div_d[REG_W-1:DIV_LSB] = wr_data[REG_W-1:DIV_LSB];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      src_q <= '0;
    end else begin
      div_q <= div_d;
      src_q <= src_d;
    end
  end

  assign src_code   = src_q[SRC_LSB +: SRC_W];
  assign src_nz     = (src_code != '0);
  assign ratio_code = div_q[DIV_LSB +: CODE_W];
  assign div_low    = div_q[DIV_LSB-1:0];
  assign div_view   = {div_q[REG_W-1] | src_nz, div_q[REG_W-2:0]};

  always_comb begin
    case (rd_addr)
      A_DIV_FULL, A_DIV_FLD: rd_data = div_view;
      A_SRC:                 rd_data = src_q;
      default:               rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ckg_core.sv
module ckg_core
  import card_clk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SH_W-1:0] pend_shift,
  input  logic            pend_run,
  output logic [SH_W-1:0] act_shift,
  output logic            act_run,
  output logic            wrap,
  output logic            ck_div,
  output logic            ce
);
  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic             run_q, run_d;
  logic             ck_q, ck_d;
  logic             ce_q, ce_d;
  logic [CNT_W:0]   span_q, span_d;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_d;

  // period length of the active setting; off state reloads every cycle
  assign span_q   = {{CNT_W{1'b0}}, 1'b1} << sh_q;
  assign last_cnt = run_q ? (span_q[CNT_W-1:0] - CNT_W'(1)) : '0;
  assign wrap     = (cnt_q == last_cnt);

  always_comb begin
    sh_d  = sh_q;
    run_d = run_q;
    cnt_d = cnt_q + CNT_W'(1);
    if (wrap) begin
      sh_d  = pend_shift;
      run_d = pend_run;
      cnt_d = '0;
    end
  end

  assign span_d = {{CNT_W{1'b0}}, 1'b1} << sh_d;
  assign half_d = span_d[CNT_W:1];

  always_comb begin
    ck_d = run_d && (sh_d != '0) && (cnt_d < half_d);
    ce_d = run_d && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      run_q <= 1'b0;
      ck_q  <= 1'b0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      run_q <= run_d;
      ck_q  <= ck_d;
      ce_q  <= ce_d;
    end
  end

  assign act_shift = sh_q;
  assign act_run   = run_q;
  assign ck_div    = ck_q;
  assign ce        = ce_q;
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_req,
  input  logic ck_div,
  output logic card_clk
);
  logic byp_q;

  // enable captured while the source clock is low, as a clock gate does
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_req;
  end

  assign card_clk = ck_div | (clk & byp_q);
endmodule

// File: rtl/card_clkgen.sv
module card_clkgen
  import card_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              card_clk,
  output logic              card_ce
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync;
  logic [CODE_W-1:0]      ratio_code;
  logic [SRC_W-1:0]       src_code;
  logic [DIV_LSB-1:0]     div_low;
  logic [SH_W-1:0]        pend_shift;
  logic                   pend_run;
  logic [SH_W-1:0]        act_shift;
  logic                   act_run;
  logic                   wrap;
  logic                   ck_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync = rst_pipe[SYNC_STAGES-1];

  ckg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .ratio_code (ratio_code),
    .src_code   (src_code),
    .div_low    (div_low)
  );

  assign pend_shift = ratio_shift(ratio_code);
  assign pend_run   = src_runs(src_code);

  ckg_core u_core (
    .clk        (clk),
    .rst_n      (rst_sync),
    .pend_shift (pend_shift),
    .pend_run   (pend_run),
    .act_shift  (act_shift),
    .act_run    (act_run),
    .wrap       (wrap),
    .ck_div     (ck_div),
    .ce         (card_ce)
  );

  ckg_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync),
    .byp_req  (act_run && (act_shift == '0)),
    .ck_div   (ck_div),
    .card_clk (card_clk)
  );
endmodule

// File: rtl/card_clkgen_chk.sv
module card_clkgen_chk
  import card_clk_pkg::*;
(
  input logic               clk,
  input logic               rst_i,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [REG_W-1:0]   rd_data,
  input logic [SRC_W-1:0]   src_code,
  input logic [DIV_LSB-1:0] div_low,
  input logic [SH_W-1:0]    act_shift,
  input logic               act_run,
  input logic               wrap,
  input logic               ck_div,
  input logic               card_ce
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_i) |-> (!card_ce && !ck_div));

  assert_switch_at_edge_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (!$stable(act_shift) || !$stable(act_run)) |-> $past(wrap));

  assert_ce_in_high_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (card_ce && act_shift != '0) |-> ck_div);

  assert_bypass_ce_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (act_run && act_shift == '0) |-> card_ce);

  assert_gated_off_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !act_run |-> (!card_ce && !ck_div));

  assert_field_keeps_low_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && wr_addr == A_DIV_FLD) |=> $stable(div_low));

  assert_mode_flag_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_addr == A_DIV_FULL && src_code != '0) |-> rd_data[REG_W-1]);
endmodule

bind card_clkgen card_clkgen_chk u_chk (
  .clk       (clk),
  .rst_i     (rst_sync),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .src_code  (src_code),
  .div_low   (div_low),
  .act_shift (act_shift),
  .act_run   (act_run),
  .wrap      (wrap),
  .ck_div    (ck_div),
  .card_ce   (card_ce)
);

// File: tb/sim_card_clkgen.sv
module sim_card_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        card_clk;
  logic        card_ce;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  card_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .card_clk(card_clk), .card_ce(card_ce)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_div = 0, m_src = 0;
  int a_sh = 0, a_run = 0, cnt = 0;
  bit e_ck = 0, e_ce = 0, byp_old = 0;

  function automatic int shift_of(input int code);
    int tbl[8] = '{0, 1, 2, 3, 4, 5, 7, 9};
    return tbl[code & 7];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_src = 0; a_sh = 0; a_run = 0; cnt = 0;
      e_ck = 0; e_ce = 0; byp_old = 0;
    end else begin
      int period, p_sh, p_run, sc;
      byp_old = (a_run != 0) && (a_sh == 0);
      p_sh  = shift_of((m_div >> 28) & 7);
      sc    = (m_src >> 16) & 15;
      p_run = (sc >= 1 && sc <= 7) ? 1 : 0;
      period = a_run ? (1 << a_sh) : 1;
      if (cnt == period - 1) begin
        a_sh = p_sh; a_run = p_run; cnt = 0;
      end else cnt++;
      e_ck = (a_run != 0) && (a_sh > 0) && (cnt < ((1 << a_sh) >> 1));
      e_ce = (a_run != 0) && (cnt == 0);
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_div = wr_data;
          2'd1: m_src = wr_data;
          2'd2: m_div = (m_div & 32'h0FFF_FFFF) | (wr_data & 32'hF000_0000);
          default: ;
        endcase
      end
    end
    #2;
    check(cur_req, {31'd0, card_clk}, {31'd0, e_ck | byp_old});
    check("R5", {31'd0, card_ce}, {31'd0, e_ce});
    #5;
    check(cur_req, {31'd0, card_clk}, {31'd0, e_ck});
    check("R5", {31'd0, card_ce}, {31'd0, e_ce});
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #6;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #6;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    rd_addr = a; #1;
    check(req, rd_data, exp);
    rd_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(6);
    // R1: reset state
    reg_rd(2'd0, 32'd0, "R1");
    reg_rd(2'd1, 32'd0, "R1");
    check("R1", {30'd0, card_clk, card_ce}, 32'd0);

    // R6: ratio 1 bypass with a running source
    cur_req = "R6";
    reg_wr(2'd1, 32'h0003_0000);
    idle(20);

    // R2: every ratio code, several periods each
    cur_req = "R2";
    for (int c = 1; c < 8; c++) begin
      reg_wr(2'd2, {1'b0, 3'(c), 28'd0});
      idle(3 * (1 << shift_of(c)) + 4);
    end
    // R3: duty check at ratio 4 and 16
    cur_req = "R3";
    reg_wr(2'd2, 32'h2000_0000);
    idle(40);
    reg_wr(2'd2, 32'h4000_0000);
    idle(70);

    // R4: changes mid-period and at varying phases
    cur_req = "R4";
    reg_wr(2'd2, 32'h6000_0000);
    idle(37);
    reg_wr(2'd2, 32'h1000_0000);
    idle(300);
    for (int k = 0; k < 6; k++) begin
      reg_wr(2'd2, {1'b0, 3'(k % 4), 28'd0});
      idle(k);
    end
    reg_wr(2'd2, 32'h0000_0000);
    idle(5);
    reg_wr(2'd2, 32'h3000_0000);
    idle(40);

    // R7: gating codes and every running code
    cur_req = "R7";
    reg_wr(2'd1, 32'h0000_0000); idle(30);
    reg_wr(2'd1, 32'h0008_0000); idle(30);
    reg_wr(2'd1, 32'h000F_0000); idle(30);
    for (int s = 1; s < 8; s++) begin
      reg_wr(2'd1, {12'd0, 4'(s), 16'd0});
      idle(20);
    end
    reg_wr(2'd2, 32'h0000_0000); idle(5);
    reg_wr(2'd1, 32'h0009_0000); idle(10);
    reg_wr(2'd1, 32'h0005_0000); idle(10);

    // R10: full writes and read map
    cur_req = "R10";
    reg_wr(2'd1, 32'h1237_ABCD);
    reg_rd(2'd1, 32'h1237_ABCD, "R10");
    reg_wr(2'd0, 32'h3123_4567);
    reg_rd(2'd0, 32'hB123_4567, "R10");
    reg_rd(2'd3, 32'h0000_0000, "R10");
    idle(30);
    // R8: field write keeps low bits
    cur_req = "R8";
    reg_wr(2'd2, 32'h5ABC_DEF0);
    reg_rd(2'd2, 32'hD123_4567, "R8");
    idle(40);
    // R9: mode flag follows source code
    cur_req = "R9";
    reg_wr(2'd1, 32'h0000_0000);
    reg_rd(2'd0, 32'h5123_4567, "R9");
    reg_wr(2'd1, 32'h000C_0000);
    reg_rd(2'd0, 32'hD123_4567, "R9");
    idle(20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule